// File: doc/BRIEF.md
# Parallel Host-to-68000 Bus Bridge

This block sits between a host that owns a narrow parallel port and a 68000-style asynchronous bus. The host shares a single 16-bit input word for everything it sends, and marks each transfer with a rising edge on a phase strobe. A 3-bit command travels with each strobe. Bit 0 of the command selects read, bit 1 selects byte size, and bit 2 selects the status word. Each host access therefore has several steps: the low address half, then the high address bits, then (for writes only) the data word. After these steps the bridge runs exactly one bus cycle. The strobe comes from another clock domain, so it passes through a two-flop synchroniser before anything acts on it.

In the bus cycle the bridge drives the address strobe together with one or both data strobes. For byte accesses, address bit 0 picks the lane. The cycle ends on the first clock that samples the acknowledge input low. If no acknowledge arrives, it ends after a fixed number of clocks, and that case is recorded as a timeout. Read results are steered into the low byte for byte accesses.

A single line tells the host when it may proceed. For writes it stays high while the bus cycle is in flight. For reads and status reads it goes high when the return word sits on the output port. The bridge drives that port only while it holds a return word. A separate active-low line signals a nonzero interrupt priority level, so the host knows to fetch the status word. A 32-bit host transfer is simply two independent word accesses.

Top module: `hbus_bridge`

## Requirements
- R1: A phase is taken on each rising edge of `host_stb`, seen after two synchronising flops. In the idle state the command codes are: 000 word write, 001 word read, 010 byte write, 011 byte read, 100 status read. Codes 101 to 111 are ignored: they start no bus cycle, do not drive the port and do not raise `host_ack`.
- R2: The first phase of a bus command latches `host_din[15:0]` as address bits 15:0. The second phase latches `host_din[7:0]` as address bits 23:16. `bus_addr` carries address bits 23:1 for the whole cycle.
- R3: A word access asserts both `bus_uds_n` and `bus_lds_n` with `bus_as_n`. `bus_rnw` is 0 for writes and 1 for reads. On a write, the data word from the third phase appears on `bus_dout` with `bus_doe` high. On a read, the full bus word is returned.
- R4: A byte access to an even address (bit 0 = 0) asserts only `bus_uds_n`. A byte access to an odd address asserts only `bus_lds_n`. A byte write passes the host data word unchanged.
- R5: A byte read returns bus bits 15:8 for an even address and bus bits 7:0 for an odd address. The result sits in `host_dout[7:0]`, and bits 15:8 read as zero.
- R6: The status read returns the registered interrupt level in bits 15:13 and the timeout flag in bit 0. All other bits are zero.
- R7: A bus cycle ends on the first clock that samples `bus_dtack_n` low. If no acknowledge comes, it ends after TIMEOUT clocks with strobes low (default 64). A timed-out cycle sets the timeout flag, and a cycle that ends with an acknowledge clears it.
- R8: `host_ack` is high while a write's bus cycle is pending and falls when it ends. For reads and status reads it goes high when the return word is on `host_dout`, and it stays high until the next strobe.
- R9: `host_doe` is high only while a return word is held. The next strobe releases it and returns the bridge to idle.
- R10: `host_int_n` is low exactly when the interrupt level sampled on the previous clock is nonzero.
- R11: A synchronous reset leaves the bridge idle. All bus strobes are high, `bus_doe`, `host_doe` and `host_ack` are low, and the timeout flag is clear.
- R12: Two successive word writes to A and A+2 run as two separate bus cycles in issue order, each carrying its own address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_cmd | input | 3 | Command code sampled with each phase |
| host_stb | input | 1 | Phase strobe, asynchronous, rising edge marks a phase |
| host_din | input | 16 | Shared host word: address halves or write data |
| host_dout | output | 16 | Return word (read data or status) |
| host_doe | output | 1 | Output enable for the host port |
| host_ack | output | 1 | Busy/done line for the host |
| host_int_n | output | 1 | Interrupt pending, active low |
| irq_ipl | input | 3 | Interrupt priority level from the bus side |
| bus_addr | output | 23 | Bus address bits 23:1 |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Bus data output enable |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low |

## Verification
Word and byte accesses run at both even and odd addresses. The patterns are chosen so that a swapped lane or a wrong byte steer shows up as a different strobe pair or a different returned byte. Acknowledge delays are short, long and never, which separates a cycle that ends on acknowledge from one that ends on the counter. The status word after each of these shows whether the timeout flag is set and cleared correctly. Other stimulus covers an undefined command code, a changing interrupt level, and a pair of word writes to A and A+2; these show that ignored codes leave the port untouched and that split transfers stay ordered. A behavioural model tracks every output on every clock, so any off-by-one in the synchroniser or phase timing is flagged even when the end result is correct.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

    // command encoding: bit0 = read, bit1 = byte, bit2 = status word
    localparam logic [2:0] HC_WORD_WR = 3'b000;
    localparam logic [2:0] HC_WORD_RD = 3'b001;
    localparam logic [2:0] HC_BYTE_WR = 3'b010;
    localparam logic [2:0] HC_BYTE_RD = 3'b011;
    localparam logic [2:0] HC_STATUS  = 3'b100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADRH,
        PH_WDAT,
        PH_BUSY,
        PH_RETN
    } phase_e;

    function automatic logic cmd_is_bus(input logic [2:0] c);
        return c[2] == 1'b0;
    endfunction

    function automatic logic cmd_is_status(input logic [2:0] c);
        return c == HC_STATUS;
    endfunction

endpackage

// File: rtl/hbb_edge_sync.sv
module hbb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] chain_d;
    logic [LEN-1:0] chain_q;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // last synchronised sample high, one older sample low
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/hbb_bus_engine.sv
module hbb_bus_engine #(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int TMO = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          rnw,
    input  logic          is_byte,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [AW-2:0] bus_addr,
    output logic          as_n,
    output logic          uds_n,
    output logic          lds_n,
    output logic          rnw_o,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    input  logic          dtack_n,
    output logic          done,
    output logic          done_tmo,
    output logic [DW-1:0] rdata
);
    localparam int CW = $clog2(TMO + 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic          done;
        logic          tmo;
        logic [DW-1:0] rd;
    } eng_t;

    eng_t e_d;
    eng_t e_q;
    logic up_en;
    logic lo_en;

    always_comb begin
        up_en = !is_byte || !addr[0];
        lo_en = !is_byte ||  addr[0];
    end

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        if (e_q.act) begin
            if (!dtack_n) begin
                e_d.act  = 1'b0;
                e_d.done = 1'b1;
                e_d.tmo  = 1'b0;
                e_d.rd   = bus_din;
            end else if (e_q.cnt == CW'(TMO - 1)) begin
                e_d.act  = 1'b0;
                e_d.done = 1'b1;
                e_d.tmo  = 1'b1;
            end else begin
                e_d.cnt = e_q.cnt + 1'b1;
            end
        end else if (go) begin
            e_d.act = 1'b1;
            e_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign bus_addr = addr[AW-1:1];
    assign as_n     = ~e_q.act;
    assign uds_n    = ~(e_q.act & up_en);
    assign lds_n    = ~(e_q.act & lo_en);
    assign rnw_o    = e_q.act ? rnw : 1'b1;
    assign bus_dout = wdata;
    assign bus_doe  = e_q.act & ~rnw;
    assign done     = e_q.done;
    assign done_tmo = e_q.tmo;
    assign rdata    = e_q.rd;

    // independent run-length count of strobe-low clocks
    logic [CW:0] chk_low_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_low_q <= '0;
        end else if (!as_n) begin
            chk_low_q <= chk_low_q + 1'b1;
        end else begin
            chk_low_q <= '0;
        end
    end

    assert_cycle_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        !as_n |-> chk_low_q < (CW+1)'(TMO));

    assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (!as_n && is_byte) |-> $countones({uds_n, lds_n}) == 1);

    assert_word_both_lanes_R3: assert property (@(posedge clk) disable iff (rst)
        (!as_n && !is_byte) |-> (!uds_n && !lds_n));

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
        (!as_n && !$fell(as_n)) |-> $stable(addr));

endmodule

// File: rtl/hbb_phase_ctl.sv
module hbb_phase_ctl
    import hbb_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic [2:0]    host_cmd,
    input  logic [DW-1:0] host_din,
    input  logic [IW-1:0] irq_ipl,
    input  logic          done,
    input  logic          done_tmo,
    input  logic [DW-1:0] rdata,
    output logic          go,
    output logic          rnw,
    output logic          is_byte,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] host_dout,
    output logic          host_doe,
    output logic          host_ack,
    output logic          host_int_n
);
    localparam int BW  = DW / 2;
    localparam int HIW = AW - DW;

    typedef struct packed {
        phase_e        ph;
        logic [2:0]    cmd;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] ret;
        logic          go;
        logic          tmo;
        logic [IW-1:0] ipl;
    } ctl_t;

    ctl_t c_d;
    ctl_t c_q;
    logic [DW-1:0] status_w;
    logic [DW-1:0] rd_steer;

    always_comb begin
        status_w          = '0;
        status_w[DW-1 -: IW] = c_q.ipl;
        status_w[0]       = c_q.tmo;
        if (!c_q.cmd[1]) begin
            rd_steer = rdata;
        end else if (!c_q.addr[0]) begin
            rd_steer = {{BW{1'b0}}, rdata[DW-1 -: BW]};
        end else begin
            rd_steer = {{BW{1'b0}}, rdata[BW-1:0]};
        end
    end

    always_comb begin
        c_d     = c_q;
        c_d.go  = 1'b0;
        c_d.ipl = irq_ipl;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (rise) begin
                    if (cmd_is_status(host_cmd)) begin
                        c_d.ret = status_w;
                        c_d.ph  = PH_RETN;
                    end else if (cmd_is_bus(host_cmd)) begin
                        c_d.cmd           = host_cmd;
                        c_d.addr[DW-1:0]  = host_din;
                        c_d.ph            = PH_ADRH;
                    end
                end
            end
            PH_ADRH: begin
                if (rise) begin
                    c_d.addr[AW-1:DW] = host_din[HIW-1:0];
                    if (c_q.cmd[0]) begin
                        c_d.go = 1'b1;
                        c_d.ph = PH_BUSY;
                    end else begin
                        c_d.ph = PH_WDAT;
                    end
                end
            end
            PH_WDAT: begin
                if (rise) begin
                    c_d.wd = host_din;
                    c_d.go = 1'b1;
                    c_d.ph = PH_BUSY;
                end
            end
            PH_BUSY: begin
                if (done) begin
                    c_d.tmo = done_tmo;
                    if (c_q.cmd[0]) begin
                        c_d.ret = rd_steer;
                        c_d.ph  = PH_RETN;
                    end else begin
                        c_d.ph = PH_IDLE;
                    end
                end
            end
            PH_RETN: begin
                if (rise) begin
                    c_d.ph = PH_IDLE;
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q    <= '0;
            c_q.ph <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign go         = c_q.go;
    assign rnw        = c_q.cmd[0];
    assign is_byte    = c_q.cmd[1];
    assign addr       = c_q.addr;
    assign wdata      = c_q.wd;
    assign host_dout  = c_q.ret;
    assign host_doe   = (c_q.ph == PH_RETN);
    assign host_ack   = (c_q.ph == PH_RETN) | ((c_q.ph == PH_BUSY) & ~c_q.cmd[0]);
    assign host_int_n = (c_q.ipl == '0);

    logic chk_arm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_arm_q <= 1'b0;
        end else begin
            chk_arm_q <= 1'b1;
        end
    end

    assert_int_tracks_level_R10: assert property (@(posedge clk) disable iff (rst)
        chk_arm_q |-> (host_int_n == ($past(irq_ipl) == '0)));

    assert_done_only_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (c_q.ph == PH_BUSY));

endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge #(
    parameter int AW      = 24,
    parameter int DW      = 16,
    parameter int IW      = 3,
    parameter int TIMEOUT = 64,
    parameter int SYNC    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    host_cmd,
    input  logic          host_stb,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] host_dout,
    output logic          host_doe,
    output logic          host_ack,
    output logic          host_int_n,
    input  logic [IW-1:0] irq_ipl,
    output logic [AW-2:0] bus_addr,
    output logic          bus_as_n,
    output logic          bus_uds_n,
    output logic          bus_lds_n,
    output logic          bus_rnw,
    output logic [DW-1:0] bus_dout,
    output logic          bus_doe,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_dtack_n
);
    logic          stb_rise;
    logic          go;
    logic          rnw;
    logic          is_byte;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          done;
    logic          done_tmo;
    logic [DW-1:0] rdata;

    hbb_edge_sync #(.STAGES(SYNC)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (host_stb),
        .rise (stb_rise)
    );

    hbb_phase_ctl #(.AW(AW), .DW(DW), .IW(IW)) i_ctl (
        .clk        (clk),
        .rst        (rst),
        .rise       (stb_rise),
        .host_cmd   (host_cmd),
        .host_din   (host_din),
        .irq_ipl    (irq_ipl),
        .done       (done),
        .done_tmo   (done_tmo),
        .rdata      (rdata),
        .go         (go),
        .rnw        (rnw),
        .is_byte    (is_byte),
        .addr       (addr),
        .wdata      (wdata),
        .host_dout  (host_dout),
        .host_doe   (host_doe),
        .host_ack   (host_ack),
        .host_int_n (host_int_n)
    );

    hbb_bus_engine #(.AW(AW), .DW(DW), .TMO(TIMEOUT)) i_eng (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .rnw      (rnw),
        .is_byte  (is_byte),
        .addr     (addr),
        .wdata    (wdata),
        .bus_addr (bus_addr),
        .as_n     (bus_as_n),
        .uds_n    (bus_uds_n),
        .lds_n    (bus_lds_n),
        .rnw_o    (bus_rnw),
        .bus_dout (bus_dout),
        .bus_doe  (bus_doe),
        .bus_din  (bus_din),
        .dtack_n  (bus_dtack_n),
        .done     (done),
        .done_tmo (done_tmo),
        .rdata    (rdata)
    );

    assert_port_idle_during_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        host_doe |-> bus_as_n);

    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> (bus_as_n && !host_doe && !host_ack));

endmodule

// File: tb/test_hbus_bridge.sv
`timescale 1ns/1ps
module test_hbus_bridge;
    localparam int TMO = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_cmd = 3'd0;
    logic        host_stb = 1'b0;
    logic [15:0] host_din = 16'd0;
    logic [15:0] host_dout;
    logic        host_doe, host_ack, host_int_n;
    logic [2:0]  irq_ipl = 3'd0;
    logic [22:0] bus_addr;
    logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rnw, bus_doe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = 16'd0;
    logic        bus_dtack_n = 1'b1;

    always #2.5 clk = ~clk;

    hbus_bridge i_hbus_bridge (
        .clk(clk), .rst(rst), .host_cmd(host_cmd), .host_stb(host_stb),
        .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
        .host_ack(host_ack), .host_int_n(host_int_n), .irq_ipl(irq_ipl),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
        .bus_lds_n(bus_lds_n), .bus_rnw(bus_rnw), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_dtack_n(bus_dtack_n)
    );

    int checks = 0;
    int bad = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    // ---------------- behavioural reference, stepped on every edge
    int          m_ph;        // 0 idle 1 addr-hi 2 data 3 bus 4 return
    logic [2:0]  m_cmd;
    logic [23:0] m_addr;
    logic [15:0] m_wd, m_ret, m_rd;
    logic [2:0]  m_ipl;
    bit          m_go, m_tmo, m_done, m_dtmo, m_act, m_started;
    int          m_len;
    bit          m_samp[$];
    bit          t_rise, o_go, o_done, o_dtmo;

    always @(posedge clk) begin
        m_started = 1'b1;
        if (rst) begin
            m_ph = 0; m_cmd = 0; m_addr = 0; m_wd = 0; m_ret = 0; m_rd = 0;
            m_ipl = 0; m_go = 0; m_tmo = 0; m_done = 0; m_dtmo = 0; m_act = 0;
            m_len = 0;
            m_samp = '{0, 0, 0};
        end else begin
            t_rise = m_samp[1] && !m_samp[2];
            o_go = m_go; o_done = m_done; o_dtmo = m_dtmo;
            m_samp.push_front(host_stb);
            void'(m_samp.pop_back());
            m_done = 0;
            if (m_act) begin
                if (!bus_dtack_n) begin
                    m_act = 0; m_done = 1; m_dtmo = 0; m_rd = bus_din;
                end else if (m_len == TMO - 1) begin
                    m_act = 0; m_done = 1; m_dtmo = 1;
                end else begin
                    m_len++;
                end
            end else if (o_go) begin
                m_act = 1; m_len = 0;
            end
            m_go = 0;
            case (m_ph)
                0: if (t_rise) begin
                    if (host_cmd == 3'd4) begin
                        m_ret = {m_ipl, 12'h000, m_tmo}; m_ph = 4;
                    end else if (host_cmd < 3'd4) begin
                        m_cmd = host_cmd; m_addr[15:0] = host_din; m_ph = 1;
                    end
                end
                1: if (t_rise) begin
                    m_addr[23:16] = host_din[7:0];
                    if (m_cmd[0]) begin m_go = 1; m_ph = 3; end
                    else m_ph = 2;
                end
                2: if (t_rise) begin m_wd = host_din; m_go = 1; m_ph = 3; end
                3: if (o_done) begin
                    m_tmo = o_dtmo;
                    if (m_cmd[0]) begin
                        if (!m_cmd[1]) m_ret = m_rd;
                        else if (!m_addr[0]) m_ret = {8'h00, m_rd[15:8]};
                        else m_ret = {8'h00, m_rd[7:0]};
                        m_ph = 4;
                    end else m_ph = 0;
                end
                4: if (t_rise) m_ph = 0;
                default: m_ph = 0;
            endcase
            m_ipl = irq_ipl;
        end
    end

    // ---------------- bus slave, monitor and per-clock compare
    int          s_lat = 2;       // clocks to acknowledge, negative = never
    int          s_cnt = 0;
    int          run = 0, last_run = 0;
    logic [22:0] r_addr;
    logic        r_uds, r_lds, r_rnw;
    logic [15:0] r_wd;
    logic [22:0] cyc_addr[$];
    logic [15:0] cyc_wd[$];

    always @(negedge clk) begin
        if (m_started) begin
            chk("R4", "as_n",  bus_as_n,  !m_act);
            chk("R4", "uds_n", bus_uds_n, !(m_act && (!m_cmd[1] || !m_addr[0])));
            chk("R4", "lds_n", bus_lds_n, !(m_act && (!m_cmd[1] ||  m_addr[0])));
            chk("R3", "rnw",   bus_rnw,   m_act ? m_cmd[0] : 1'b1);
            chk("R3", "bus_doe", bus_doe, m_act && !m_cmd[0]);
            if (m_act && !m_cmd[0]) chk("R3", "bus_dout", bus_dout, m_wd);
            chk("R2", "bus_addr", bus_addr, m_addr[23:1]);
            chk("R8", "ack", host_ack, (m_ph == 4) || (m_ph == 3 && !m_cmd[0]));
            chk("R9", "doe", host_doe, m_ph == 4);
            if (m_ph == 4) chk("R5", "dout", host_dout, m_ret);
            chk("R10", "int_n", host_int_n, m_ipl == 0);
        end
        if (!bus_as_n) begin
            s_cnt++;
            bus_dtack_n = !(s_lat >= 0 && s_cnt >= s_lat);
            r_addr = bus_addr; r_uds = bus_uds_n; r_lds = bus_lds_n; r_rnw = bus_rnw;
            if (bus_doe) r_wd = bus_dout;
            run++;
        end else begin
            s_cnt = 0;
            bus_dtack_n = 1'b1;
            if (run > 0) begin
                last_run = run;
                cyc_addr.push_back(r_addr);
                cyc_wd.push_back(r_wd);
            end
            run = 0;
        end
    end

    // ---------------- watchdog
    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 100000) begin
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", wd_cnt, 100000);
            finish_run();
        end
    end

    // ---------------- host tasks
    task automatic phase(input logic [2:0] c, input logic [15:0] d);
        @(negedge clk);
        host_cmd = c; host_din = d; host_stb = 1'b1;
        repeat (4) @(negedge clk);
        host_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_ack(input logic v);
        while (host_ack !== v) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] c, input logic [23:0] a, input logic [15:0] d);
        phase(c, a[15:0]);
        phase(c, {8'h00, a[23:16]});
        phase(c, d);
        wait_ack(1'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic host_read(input logic [2:0] c, input logic [23:0] a, output logic [15:0] d);
        phase(c, a[15:0]);
        phase(c, {8'h00, a[23:16]});
        wait_ack(1'b1);
        d = host_dout;
        phase(3'd0, 16'h0000);
        repeat (2) @(negedge clk);
    endtask

    task automatic status_read(output logic [15:0] d);
        phase(3'd4, 16'h0000);
        wait_ack(1'b1);
        d = host_dout;
        phase(3'd0, 16'h0000);
        repeat (2) @(negedge clk);
    endtask

    logic [15:0] rv;

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset as_n", bus_as_n, 1'b1);
        chk("R11", "reset ack", host_ack, 1'b0);
        chk("R11", "reset doe", host_doe, 1'b0);
        chk("R11", "reset bus_doe", bus_doe, 1'b0);
        status_read(rv);
        chk("R11", "reset timeout flag", rv[0], 1'b0);

        // word write
        s_lat = 2;
        host_write(3'd0, 24'h123456, 16'hBEEF);
        chk("R2", "word write addr", r_addr, 23'(24'h123456 >> 1));
        chk("R3", "word write lanes", {r_uds, r_lds}, 2'b00);
        chk("R3", "word write rnw", r_rnw, 1'b0);
        chk("R3", "word write data", r_wd, 16'hBEEF);

        // word read
        s_lat = 3; bus_din = 16'h5A3C;
        host_read(3'd1, 24'h00ABCE, rv);
        chk("R3", "word read data", rv, 16'h5A3C);
        chk("R3", "word read rnw", r_rnw, 1'b1);
        chk("R9", "port released", host_doe, 1'b0);

        // byte writes
        s_lat = 1;
        host_write(3'd2, 24'h000100, 16'h7777);
        chk("R4", "even byte write lanes", {r_uds, r_lds}, 2'b01);
        chk("R4", "even byte write data", r_wd, 16'h7777);
        host_write(3'd2, 24'h000101, 16'h0042);
        chk("R4", "odd byte write lanes", {r_uds, r_lds}, 2'b10);
        chk("R4", "odd byte write data", r_wd, 16'h0042);

        // byte reads
        bus_din = 16'hA1B2;
        host_read(3'd3, 24'h0A0200, rv);
        chk("R5", "even byte read", rv, 16'h00A1);
        chk("R4", "even byte read lanes", {r_uds, r_lds}, 2'b01);
        host_read(3'd3, 24'h0A0201, rv);
        chk("R5", "odd byte read", rv, 16'h00B2);

        // long acknowledge: ack high while write runs
        s_lat = 20;
        phase(3'd0, 16'h0400);
        phase(3'd0, 16'h0000);
        phase(3'd0, 16'h1111);
        chk("R8", "ack during write", host_ack, 1'b1);
        chk("R8", "cycle still running", bus_as_n, 1'b0);
        wait_ack(1'b0);
        chk("R8", "cycle over when ack low", bus_as_n, 1'b1);
        repeat (2) @(negedge clk);

        // timeout
        s_lat = -1;
        host_write(3'd0, 24'h300000, 16'h2222);
        chk("R7", "timeout strobe length", last_run, TMO);
        status_read(rv);
        chk("R7", "timeout flag set", rv[0], 1'b1);
        s_lat = 2;
        host_write(3'd0, 24'h300002, 16'h3333);
        status_read(rv);
        chk("R7", "timeout flag cleared", rv[0], 1'b0);

        // interrupt level
        irq_ipl = 3'd5;
        repeat (3) @(negedge clk);
        chk("R10", "int pending", host_int_n, 1'b0);
        status_read(rv);
        chk("R6", "status level", rv[15:13], 3'd5);
        chk("R6", "status zeros", rv[12:1], 12'h000);
        irq_ipl = 3'd0;
        repeat (3) @(negedge clk);
        chk("R10", "int cleared", host_int_n, 1'b1);

        // undefined command ignored
        cyc_addr.delete(); cyc_wd.delete();
        phase(3'd5, 16'h1234);
        repeat (4) @(negedge clk);
        chk("R1", "undefined cmd doe", host_doe, 1'b0);
        chk("R1", "undefined cmd ack", host_ack, 1'b0);
        chk("R1", "undefined cmd no cycle", cyc_addr.size(), 0);
        bus_din = 16'h1357;
        host_read(3'd1, 24'h000010, rv);
        chk("R1", "read after undefined cmd", rv, 16'h1357);

        // 32-bit transfer as two word writes
        cyc_addr.delete(); cyc_wd.delete();
        host_write(3'd0, 24'h200000, 16'hCAFE);
        host_write(3'd0, 24'h200002, 16'hF00D);
        chk("R12", "cycle count", cyc_addr.size(), 2);
        if (cyc_addr.size() == 2) begin
            chk("R12", "first addr", cyc_addr[0], 23'(24'h200000 >> 1));
            chk("R12", "second addr", cyc_addr[1], 23'(24'h200002 >> 1));
            chk("R12", "first data", cyc_wd[0], 16'hCAFE);
            chk("R12", "second data", cyc_wd[1], 16'hF00D);
        end

        // synchronous reset mid-phase
        phase(3'd0, 16'h0800);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset mid access as_n", bus_as_n, 1'b1);
        chk("R11", "reset mid access ack", host_ack, 1'b0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule